// File: doc/BRIEF.md
# Dual Read Line Buffer Controller for a Flash Array

This block sits between a system bus and a 256-Kbyte on-chip flash array. It decodes each bus address against a programmable array base address. It keeps two independent 32-byte line buffers: one serves the lower half of the array and the other serves the upper half.

A read whose line is already held in its half's buffer is answered one clock later. A read that misses requests the whole line from the array. The data comes back after a programmable wait of 2 to 5 clocks, and the line is kept for later reads.

The block carves a 32-byte control-register window out of the array decode. It leaves plain writes unacknowledged, acknowledges interlock writes, and drops both buffers on an invalidate strobe. The bus holds `bus_req` and its qualifiers steady until it sees the one-cycle `bus_ack`, then removes the request for at least one cycle. An access the block does not claim is never acknowledged. The array itself is behavioural: during a fill the block holds `arr_req` high with a line address on `arr_addr`. It takes the line from `arr_rdata` in the last fill cycle.

Top module: `flash_line_reader`

## Requirements
- R1: An address belongs to the array when it lies within 256 Kbytes at or above the base formed by clearing the low N bits of `cfg_base`. `cfg_align` selects N: 00 gives 16, 01 gives 17, and 10 or 11 give 18. Any address outside that range is never acknowledged and starts no fetch.
- R2: A read whose line (address bits 23:5) matches the valid tag of its half's buffer is acknowledged in the cycle after acceptance. It starts no fetch. `bus_rdata` carries the 32-bit word at byte `(addr[4:2])*4` of the held line, and address bits 1:0 are ignored.
- R3: A read that misses is acknowledged `cfg_wait+2` cycles after acceptance (00→2, 01→3, 10→4, 11→5). `arr_req` is high for exactly `cfg_wait+1` cycles, with a steady `arr_addr` equal to the line address. The ack falls in the cycle after the last fill cycle and returns word `addr[4:2]` of `arr_rdata`, where word i sits at bits `32*i+31:32*i`.
- R4: Bit 17 of the offset from the base selects the upper buffer, and a clear bit 17 selects the lower one. Filling one buffer never changes the line held by the other.
- R5: An access whose line address equals `creg_line` is never acknowledged and starts no fetch, even when it falls inside the array.
- R6: A write to the array with `bus_interlock` low is never acknowledged. A write to the array with `bus_interlock` high is acknowledged one cycle after acceptance, starts no fetch and leaves both buffers unchanged.
- R7: A cycle with `inv_req` high clears both valid flags, so the next read to any line misses.
- R8: If `inv_req` is high during a fill, that fill still returns its data, but the filled line is not marked valid.
- R9: After reset `bus_ack` and `arr_req` are low and both buffers are invalid.
- R10: `bus_ack` is a single-cycle pulse, and each accepted access yields exactly one acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | 24 | Array base address (low N bits ignored) |
| cfg_align | input | 2 | Base alignment select |
| cfg_wait | input | 2 | Miss latency select |
| creg_line | input | 19 | Line address of the control-register window |
| bus_req | input | 1 | Access request, held until acknowledge |
| bus_we | input | 1 | Access is a write |
| bus_interlock | input | 1 | Write is a program/erase interlock write |
| bus_addr | input | 24 | Byte address |
| bus_ack | output | 1 | One-cycle acknowledge |
| bus_rdata | output | 32 | Read data, valid with acknowledge |
| inv_req | input | 1 | Invalidate both line buffers |
| arr_req | output | 1 | Array line fetch in progress |
| arr_addr | output | 19 | Line address being fetched |
| arr_rdata | input | 256 | Line returned by the array |

## Verification
The hardest case to reach from the ports is an invalidate that lands in the middle of a line fill. The fill must complete and return fresh data while its line stays invalid. The bench sets the longest wait, starts a miss, and raises `inv_req` on the second fill cycle. It then re-reads the same line and expects a full miss latency. Buffer origin is proven by changing the array contents between reads: hits must keep returning the old generation of data, while misses pick up the new one.

// File: rtl/flr_pkg.sv
package flr_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } flr_state_e;
endpackage

// File: rtl/flr_decode.sv
module flr_decode #(
  parameter int ADDR_W     = 24,
  parameter int ARRAY_LOG2 = 18,
  parameter int LINE_LOG2  = 5
) (
  input  logic [ADDR_W-1:0]           addr,
  input  logic [ADDR_W-1:0]           cfg_base,
  input  logic [1:0]                  cfg_align,
  input  logic [ADDR_W-LINE_LOG2-1:0] creg_line,
  output logic                        in_module,
  output logic                        upper
);
  localparam int N_MIN = ARRAY_LOG2 - 2;
  localparam logic [ADDR_W-1:0] ARR_SIZE = ADDR_W'(1) << ARRAY_LOG2;

  logic [ADDR_W-1:0] mask;
  logic [ADDR_W-1:0] abase;
  logic [ADDR_W-1:0] ofs;
  logic              in_arr;
  logic              in_creg;

  always_comb begin
    case (cfg_align)
      2'b00:   mask = {ADDR_W{1'b1}} << N_MIN;
      2'b01:   mask = {ADDR_W{1'b1}} << (N_MIN + 1);
      default: mask = {ADDR_W{1'b1}} << ARRAY_LOG2;
    endcase
    abase     = cfg_base & mask;
    ofs       = addr - abase;
    in_arr    = (addr >= abase) && (ofs < ARR_SIZE);
    in_creg   = (addr[ADDR_W-1:LINE_LOG2] == creg_line);
    in_module = in_arr && !in_creg;
    upper     = ofs[ARRAY_LOG2-1];
  end
endmodule

// File: rtl/flr_line_buf.sv
module flr_line_buf #(
  parameter int TAG_W  = 19,
  parameter int LINE_W = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv,
  input  logic              wr,
  input  logic              set_v,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [TAG_W-1:0]  look_tag,
  output logic              hit,
  output logic              valid,
  output logic [LINE_W-1:0] line
);
  logic              valid_q, valid_d;
  logic [TAG_W-1:0]  tag_q;
  logic [LINE_W-1:0] line_q;

  always_comb begin
    if (inv)     valid_d = 1'b0;
    else if (wr) valid_d = set_v;
    else         valid_d = valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr) begin
      tag_q  <= wr_tag;
      line_q <= wr_line;
    end
  end

  assign hit   = valid_q && (tag_q == look_tag);
  assign valid = valid_q;
  assign line  = line_q;
endmodule

// File: rtl/flr_seq.sv
module flr_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_req,
  input  logic       bus_we,
  input  logic       bus_interlock,
  input  logic       in_module,
  input  logic       hit,
  input  logic       inv_req,
  input  logic [1:0] cfg_wait,
  output logic       start_fill,
  output logic       quick,
  output logic       fill_done,
  output logic       keep_valid,
  output logic       busy,
  output logic       ack_next,
  output logic       ack
);
  import flr_pkg::*;

  flr_state_e state_q, state_d;
  logic [2:0] cnt_q, cnt_d;
  logic       inv_seen_q, inv_seen_d;
  logic       ack_q;
  logic       accept;

  always_comb begin
    accept     = (state_q == ST_IDLE) && bus_req && !ack_q && in_module &&
                 (!bus_we || bus_interlock);
    start_fill = accept && !bus_we && !hit;
    quick      = accept && (bus_we || hit);
    fill_done  = (state_q == ST_FILL) && (cnt_q == 3'd1);
    keep_valid = !inv_seen_q && !inv_req;
    ack_next   = quick || fill_done;

    state_d    = state_q;
    cnt_d      = cnt_q;
    inv_seen_d = inv_seen_q;
    if (start_fill) begin
      state_d    = ST_FILL;
      cnt_d      = {1'b0, cfg_wait} + 3'd1;
      inv_seen_d = 1'b0;
    end else if (state_q == ST_FILL) begin
      if (inv_req) inv_seen_d = 1'b1;
      if (fill_done) state_d = ST_IDLE;
      else           cnt_d   = cnt_q - 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= 3'd0;
      inv_seen_q <= 1'b0;
      ack_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      inv_seen_q <= inv_seen_d;
      ack_q      <= ack_next;
    end
  end

  assign busy = (state_q == ST_FILL);
  assign ack  = ack_q;
endmodule

// File: rtl/flash_line_reader.sv
module flash_line_reader #(
  parameter int ADDR_W     = 24,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int ARRAY_LOG2 = 18,
  parameter int NBUF       = 2,
  localparam int LINE_LOG2 = $clog2(LINE_BYTES),
  localparam int TAG_W     = ADDR_W - LINE_LOG2,
  localparam int LINE_W    = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [1:0]        cfg_align,
  input  logic [1:0]        cfg_wait,
  input  logic [TAG_W-1:0]  creg_line,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic              bus_interlock,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              bus_ack,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              inv_req,
  output logic              arr_req,
  output logic [TAG_W-1:0]  arr_addr,
  input  logic [LINE_W-1:0] arr_rdata
);
  localparam int WORDS     = LINE_W / WORD_W;
  localparam int WIDX_W    = $clog2(WORDS);
  localparam int BYTE_LOG2 = $clog2(WORD_W / 8);

  logic              rst_meta, rst_ns;
  logic              in_module, upper;
  logic              start_fill, quick, fill_done, keep_valid, busy, ack_next;
  logic [NBUF-1:0]   hit_v, buf_valid;
  logic [LINE_W-1:0] line_v [NBUF];
  logic              hit;
  logic [TAG_W-1:0]  bus_tag;
  logic [WIDX_W-1:0] bus_widx;
  logic [TAG_W-1:0]  req_tag_q;
  logic [WIDX_W-1:0] req_widx_q;
  logic              req_upper_q;
  logic [WORD_W-1:0] rdata_q, rdata_d;

  // reset asserts at once, leaves on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ns   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ns   <= rst_meta;
    end
  end

  assign bus_tag  = bus_addr[ADDR_W-1:LINE_LOG2];
  assign bus_widx = bus_addr[LINE_LOG2-1:BYTE_LOG2];

  flr_decode #(
    .ADDR_W(ADDR_W), .ARRAY_LOG2(ARRAY_LOG2), .LINE_LOG2(LINE_LOG2)
  ) u_decode (
    .addr(bus_addr), .cfg_base(cfg_base), .cfg_align(cfg_align),
    .creg_line(creg_line), .in_module(in_module), .upper(upper)
  );

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    logic sel_b;
    assign sel_b = (b == 1) ? req_upper_q : !req_upper_q;
    flr_line_buf #(.TAG_W(TAG_W), .LINE_W(LINE_W)) u_buf (
      .clk(clk), .rst_n(rst_ns), .inv(inv_req),
      .wr(fill_done && sel_b), .set_v(keep_valid),
      .wr_tag(req_tag_q), .wr_line(arr_rdata),
      .look_tag(bus_tag), .hit(hit_v[b]), .valid(buf_valid[b]),
      .line(line_v[b])
    );
  end

  assign hit = upper ? hit_v[1] : hit_v[0];

  flr_seq u_seq (
    .clk(clk), .rst_n(rst_ns), .bus_req(bus_req), .bus_we(bus_we),
    .bus_interlock(bus_interlock), .in_module(in_module), .hit(hit),
    .inv_req(inv_req), .cfg_wait(cfg_wait), .start_fill(start_fill),
    .quick(quick), .fill_done(fill_done), .keep_valid(keep_valid),
    .busy(busy), .ack_next(ack_next), .ack(bus_ack)
  );

  always_comb begin
    if (fill_done)
      rdata_d = arr_rdata[req_widx_q*WORD_W +: WORD_W];
    else if (quick && !bus_we)
      rdata_d = line_v[upper][bus_widx*WORD_W +: WORD_W];
    else
      rdata_d = '0;
  end

  always_ff @(posedge clk) begin
    if (start_fill) begin
      req_tag_q   <= bus_tag;
      req_widx_q  <= bus_widx;
      req_upper_q <= upper;
    end
    if (ack_next) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
  assign arr_req   = busy;
  assign arr_addr  = req_tag_q;
endmodule

// File: rtl/flr_checker.sv
module flr_checker #(
  parameter int TAG_W = 19
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_req,
  input logic             bus_we,
  input logic             bus_interlock,
  input logic             bus_ack,
  input logic             arr_req,
  input logic [TAG_W-1:0] arr_addr,
  input logic             inv_req,
  input logic [1:0]       cfg_wait,
  input logic [1:0]       buf_valid
);
  logic [3:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       len_q <= 4'd0;
    else if (arr_req) len_q <= len_q + 4'd1;
    else              len_q <= 4'd0;
  end

  p_fill_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(arr_req) |-> (len_q == {2'b00, cfg_wait} + 4'd1));

  p_ack_after_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(arr_req) |-> bus_ack);

  p_addr_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_req && $past(arr_req)) |-> $stable(arr_addr));

  p_plain_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && !bus_interlock && !arr_req && !bus_ack) |=> !bus_ack);

  p_inv_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inv_req |=> (buf_valid == 2'b00));

  p_ack_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);
endmodule

bind flash_line_reader flr_checker #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_ns), .bus_req(bus_req), .bus_we(bus_we),
  .bus_interlock(bus_interlock), .bus_ack(bus_ack), .arr_req(arr_req),
  .arr_addr(arr_addr), .inv_req(inv_req), .cfg_wait(cfg_wait),
  .buf_valid(buf_valid)
);

// File: tb/flash_line_reader_bench.sv
`timescale 1ns/1ps
module flash_line_reader_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [23:0]  cfg_base;
  logic [1:0]   cfg_align, cfg_wait;
  logic [18:0]  creg_line;
  logic         bus_req, bus_we, bus_interlock, inv_req;
  logic [23:0]  bus_addr;
  logic         bus_ack, arr_req;
  logic [31:0]  bus_rdata;
  logic [18:0]  arr_addr;
  logic [255:0] arr_rdata;
  logic [7:0]   gen;

  int checks = 0, errors = 0, fills = 0, cyc = 0;
  bit m_valid [2];
  logic [18:0] m_tag [2];
  logic [7:0]  m_gen [2];

  always #2 clk = ~clk;

  flash_line_reader u_flash_line_reader (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_align(cfg_align),
    .cfg_wait(cfg_wait), .creg_line(creg_line), .bus_req(bus_req),
    .bus_we(bus_we), .bus_interlock(bus_interlock), .bus_addr(bus_addr),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .inv_req(inv_req),
    .arr_req(arr_req), .arr_addr(arr_addr), .arr_rdata(arr_rdata)
  );

  function automatic logic [31:0] wf(input logic [7:0] g, input logic [21:0] lw);
    return ({10'd0, lw} * 32'd40503) ^ {g, 24'h00_0000};
  endfunction

  always_comb
    for (int i = 0; i < 8; i++)
      arr_rdata[i*32 +: 32] = wf(gen, {arr_addr, 3'(i)});

  always @(posedge clk) begin
    cyc++;
    if (arr_req) fills++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic bit claims(input logic [23:0] a, output bit up);
    int n;
    logic [23:0] ab, ofs;
    n   = (cfg_align >= 2) ? 18 : 16 + int'(cfg_align);
    ab  = cfg_base & ~((24'h1 << n) - 24'h1);
    ofs = a - ab;
    up  = ofs[17];
    return (a >= ab) && (ofs < 24'h40000) && (a[23:5] != creg_line);
  endfunction

  task automatic access(input logic [23:0] a, input logic we, input logic il,
                        input int inv_at, input string rq);
    bit up, inm, hit, claim, got;
    int cnt, exp_lat, f0, h;
    logic [31:0] exp_d;
    inm   = claims(a, up);
    h     = up ? 1 : 0;
    claim = inm && (!we || il);
    hit   = !we && m_valid[h] && (m_tag[h] == a[23:5]);
    exp_lat = !claim ? 0 : (we || hit) ? 1 : int'(cfg_wait) + 2;
    exp_d = hit ? wf(m_gen[h], a[23:2]) : wf(gen, a[23:2]);
    bus_addr = a; bus_we = we; bus_interlock = il; bus_req = 1'b1;
    f0 = fills; cnt = 0; got = 0;
    while (cnt < 10 && !got) begin
      @(negedge clk);
      cnt++;
      inv_req = (cnt == inv_at);
      if (inv_req) begin m_valid[0] = 0; m_valid[1] = 0; end
      if (bus_ack) got = 1;
    end
    inv_req = 1'b0;
    bus_req = 1'b0;
    chk({rq, " latency"}, got ? cnt : 0, exp_lat);
    if (got && !we) chk({rq, " data"}, bus_rdata, exp_d);
    @(negedge clk);
    chk("R10 ack pulse", {31'd0, bus_ack}, 0);
    chk({rq, " fetch cycles"}, fills - f0, (claim && !we && !hit) ? int'(cfg_wait) + 1 : 0);
    if (claim && !we && !hit) begin
      m_valid[h] = (inv_at == 0);
      m_tag[h]   = a[23:5];
      m_gen[h]   = gen;
    end
  endtask

  task automatic invalidate();
    inv_req = 1'b1;
    @(negedge clk);
    inv_req = 1'b0;
    m_valid[0] = 0; m_valid[1] = 0;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; bus_req = 0; bus_we = 0; bus_interlock = 0; inv_req = 0;
    bus_addr = '0; gen = 8'h11;
    cfg_base = 24'h14_0000; cfg_align = 2'b10; cfg_wait = 2'b00;
    creg_line = 19'h7FFFF;
    m_valid[0] = 0; m_valid[1] = 0;
    m_tag[0] = '0; m_tag[1] = '0; m_gen[0] = '0; m_gen[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 ack low after reset", {31'd0, bus_ack}, 0);
    chk("R9 no fetch after reset", {31'd0, arr_req}, 0);
    access(24'h14_0040, 0, 0, 0, "R9 first read misses");

    // latency sweep over every wait code, hit after miss, both halves
    for (int w = 0; w < 4; w++) begin
      cfg_wait = 2'(w);
      invalidate();
      access(24'h14_0100 + 24'(w*32), 0, 0, 0, "R3 lower miss");
      for (int k = 0; k < 8; k++)
        access(24'h14_0100 + 24'(w*32) + 24'(k*4) + 24'(k%4), 0, 0, 0, "R2 hit word");
      access(24'h16_0200 + 24'(w*32) + 24'h1C, 0, 0, 0, "R3 upper miss");
      access(24'h16_0200 + 24'(w*32), 0, 0, 0, "R2 upper hit");
    end

    // buffer independence: old data survives a change of array contents
    cfg_wait = 2'b01;
    access(24'h15_0000, 0, 0, 0, "R4 lower fill");
    access(24'h17_0008, 0, 0, 0, "R4 upper fill");
    gen = 8'h22;
    access(24'h15_0004, 0, 0, 0, "R4 lower keeps old");
    access(24'h17_000C, 0, 0, 0, "R4 upper keeps old");
    access(24'h15_FFE0, 0, 0, 0, "R4 lower refill");
    access(24'h17_0010, 0, 0, 0, "R4 upper untouched");
    access(24'h15_0000, 0, 0, 0, "R4 lower misses new");
    access(24'h15_FFFC, 0, 0, 0, "R4 last lower line");
    access(24'h16_0000, 0, 0, 0, "R4 first upper line");

    // base alignment sweep with an unaligned base value
    cfg_base = 24'h15_2345;
    for (int s = 0; s < 4; s++) begin
      logic [23:0] ab;
      int n;
      cfg_align = 2'(s);
      n  = (s >= 2) ? 18 : 16 + s;
      ab = cfg_base & ~((24'h1 << n) - 24'h1);
      gen = 8'h30 + 8'(s);
      invalidate();
      access(ab, 0, 0, 0, "R1 base start");
      access(ab + 24'h1_FFFC, 0, 0, 0, "R1 lower end");
      access(ab + 24'h2_0000, 0, 0, 0, "R1 upper start");
      access(ab + 24'h3_FFFC, 0, 0, 0, "R1 array end");
      access(ab + 24'h4_0000, 0, 0, 0, "R1 past end");
      access(ab - 24'h4, 0, 0, 0, "R1 below base");
    end

    // control-register window inside the array
    cfg_base = 24'h14_0000; cfg_align = 2'b10; cfg_wait = 2'b10;
    creg_line = 19'h0A008;
    invalidate();
    access(24'h14_0104, 0, 0, 0, "R5 window read");
    access(24'h14_011C, 0, 0, 0, "R5 window end");
    access(24'h14_0108, 1, 1, 0, "R5 window interlock write");
    access(24'h14_0120, 0, 0, 0, "R5 after window");
    access(24'h14_00FC, 0, 0, 0, "R5 before window");

    // writes
    access(24'h14_0124, 1, 0, 0, "R6 plain write");
    access(24'h14_0124, 1, 1, 0, "R6 interlock write");
    access(24'h14_0124, 0, 0, 0, "R6 buffer unchanged");
    access(24'h20_0000, 1, 1, 0, "R6 interlock outside");

    // invalidate, idle and during a fill
    cfg_wait = 2'b11;
    access(24'h14_0124, 0, 0, 0, "R7 hit before inv");
    invalidate();
    access(24'h14_0124, 0, 0, 0, "R7 miss after inv");
    access(24'h16_4444, 0, 0, 0, "R8 fill setup");
    invalidate();
    access(24'h16_4448, 0, 0, 2, "R8 fill with inv");
    access(24'h16_4448, 0, 0, 0, "R8 line not kept");
    access(24'h16_444C, 0, 0, 0, "R8 later hit");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule